// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 32-bit load/store processor built around a single shared bus. A 6-bit micro-program counter selects one word of a synthesizable control store. Each word holds a 17-bit control-point vector for the datapath and a next-state field. The next-state field names one of four successor kinds and a 6-bit target. A *sequential* word always moves to its target. A *dispatch* word jumps to the entry point that a small lookup assigns to the current 6-bit opcode. A *wait* word stays put while the memory reports busy and moves to its target once busy is low. A *branch* word moves to its target when the datapath zero flag is set and returns to the start of fetch when it is clear.

The store holds one common fetch sequence and a short sequence for each instruction group: register-register ALU, signed and unsigned immediate ALU, load word, store word, jump and branch-if-zero. Any opcode without an entry in the lookup sends the sequencer into a halt state, which only reset can leave. The control vector is a combinational read of the store at the current micro-state, so it changes one clock edge after the decision that selects that micro-state.

Top module: `microcode_seq`

## Requirements
- R1: An active-low asynchronous reset forces the micro-state to the first fetch step, abandoning any sequence in progress. While reset is low and in the first cycle after it rises, the control vector is the MA-load word of R2.
- R2: Fetch takes four steps in order. Step one loads MA from PC (reg_sel=3, en_reg, ld_ma). Step two loads IR from memory (en_mem, ld_ir) and repeats as long as busy=1. Step three loads A from PC (reg_sel=3, en_reg, ld_a). Step four writes A+4 into PC (alu_op=1, en_alu, reg_sel=3, reg_wr) and dispatches.
- R3: The dispatch in fetch step four picks the next sequence from the opcode. 6'h00 selects register-register. 6'h08 and 6'h0A select signed immediate. 6'h0C and 6'h0D select unsigned immediate. 6'h23 selects load, 6'h2B store, 6'h02 jump and 6'h04 branch-if-zero.
- R4: Any other opcode at dispatch enters a halt state. In that state the control vector is all zeros and the state does not change for any input until reset.
- R5: The register-register sequence has three steps. It loads A from rs (reg_sel=0, en_reg, ld_a), then B from rt (reg_sel=1, en_reg, ld_b), then writes the IR-decoded ALU result to rd (alu_op=2, en_alu, reg_sel=2, reg_wr). It then returns to fetch.
- R6: The immediate sequence loads A from rs and then loads B from the immediate unit (en_imm, ld_b). The extension code is 0 (sign) for the signed opcodes and 1 (zero) for the unsigned ones. It then writes the IR-decoded ALU result to rt (alu_op=2, en_alu, reg_sel=1, reg_wr) and returns to fetch.
- R7: The load sequence has four steps. It loads A from rs, then loads B with the sign-extended immediate (ext 0), then loads MA with A+B (alu_op=0, en_alu, ld_ma). The last step writes memory data into rt (en_mem, reg_sel=1, reg_wr) and repeats while busy=1 before returning to fetch.
- R8: The store sequence follows the load's first three steps. Its last step drives rt onto the bus with a memory write (reg_sel=1, en_reg, mem_wr) and repeats while busy=1 before returning to fetch.
- R9: The jump sequence loads A from PC, then loads B from the raw IR (ext 3, en_imm, ld_b). It then writes the jump target into PC (alu_op=3, en_alu, reg_sel=3, reg_wr) and returns to fetch.
- R10: The branch sequence loads A from rs. The next step loads A from PC and tests zero. When zero=0 the sequence returns to fetch. When zero=1 it loads B with the shifted sign-extended offset (ext 2, en_imm, ld_b), then writes A+B into PC (alu_op=0, en_alu, reg_sel=3, reg_wr) and returns to fetch.
- R11: At most one bus driver is on in any cycle: en_reg, en_imm, en_alu, or en_mem without mem_wr. Every word that loads a register or writes memory has exactly one driver on.
- R12: The control vector packs, from bit 16 down: ld_ir, ld_a, ld_b, ld_ma, reg_sel[2:0], reg_wr, en_reg, ext_sel[1:0], en_imm, alu_op[1:0], en_alu, mem_wr, en_mem. The reg_sel codes are rs=0, rt=1, rd=2, PC=3, link=4. Fields that a word does not use are zero.
- R13: busy affects only the two wait steps (R2, R7/R8), and zero affects only the branch test step (R10). Everywhere else the sequence is the same for either value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | Datapath flag: A register equals zero |
| busy | input | 1 | Memory access still in progress |
| ctrl | output | 17 | Datapath control points, packed as in R12 |

## Verification
The bound checker watches the micro-state on every cycle for four behaviours. It checks that the state returns to the first fetch step after reset and that the memory-read fetch step holds or advances with busy. It checks that halt is never left and that a clear zero flag in the branch test step returns to fetch. It also checks the bus rule of R11 on every control word.

Only the bench's scenarios can show the rest. These are the opcode-to-sequence mapping, the exact control word of each step, the signed versus unsigned choice and the held load and store completion. They also include the inputs ignored outside their test steps and reset in the middle of a sequence. The bench confirms all of these against its own reference model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int UPC_W = 6;
    localparam int OPC_W = 6;

    typedef logic [UPC_W-1:0] upc_t;
    typedef logic [OPC_W-1:0] opc_t;

    typedef enum logic [1:0] {
        NX_SEQ  = 2'd0,
        NX_DISP = 2'd1,
        NX_WAIT = 2'd2,
        NX_BRZ  = 2'd3
    } nxt_kind_e;

    typedef enum logic [2:0] {
        RS_RS   = 3'd0,
        RS_RT   = 3'd1,
        RS_RD   = 3'd2,
        RS_PC   = 3'd3,
        RS_LINK = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        EX_SEXT     = 2'd0,
        EX_UEXT     = 2'd1,
        EX_SEXT_SH2 = 2'd2,
        EX_IRRAW    = 2'd3
    } ext_sel_e;

    typedef enum logic [1:0] {
        AL_ADD   = 2'd0,
        AL_ADD4  = 2'd1,
        AL_IR    = 2'd2,
        AL_JTARG = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic     ld_ir;
        logic     ld_a;
        logic     ld_b;
        logic     ld_ma;
        reg_sel_e reg_sel;
        logic     reg_wr;
        logic     en_reg;
        ext_sel_e ext_sel;
        logic     en_imm;
        alu_op_e  alu_op;
        logic     en_alu;
        logic     mem_wr;
        logic     en_mem;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t     ctrl;
        nxt_kind_e kind;
        upc_t      target;
    } uinst_t;

    // micro-state addresses
    localparam upc_t U_FETCH0 = 6'd0;
    localparam upc_t U_FETCH1 = 6'd1;
    localparam upc_t U_FETCH2 = 6'd2;
    localparam upc_t U_FETCH3 = 6'd3;
    localparam upc_t U_RR0    = 6'd4;
    localparam upc_t U_RR1    = 6'd5;
    localparam upc_t U_RR2    = 6'd6;
    localparam upc_t U_IS0    = 6'd7;
    localparam upc_t U_IS1    = 6'd8;
    localparam upc_t U_IU1    = 6'd9;
    localparam upc_t U_IWB    = 6'd10;
    localparam upc_t U_IU0    = 6'd11;
    localparam upc_t U_LD0    = 6'd12;
    localparam upc_t U_LD1    = 6'd13;
    localparam upc_t U_LD2    = 6'd14;
    localparam upc_t U_LD3    = 6'd15;
    localparam upc_t U_ST0    = 6'd16;
    localparam upc_t U_ST1    = 6'd17;
    localparam upc_t U_ST2    = 6'd18;
    localparam upc_t U_ST3    = 6'd19;
    localparam upc_t U_JP0    = 6'd20;
    localparam upc_t U_JP1    = 6'd21;
    localparam upc_t U_JP2    = 6'd22;
    localparam upc_t U_BZ0    = 6'd23;
    localparam upc_t U_BZ1    = 6'd24;
    localparam upc_t U_BZ2    = 6'd25;
    localparam upc_t U_BZ3    = 6'd26;
    localparam upc_t U_HALT   = 6'd27;

    // opcodes with a dispatch entry
    localparam opc_t OP_RR   = 6'h00;
    localparam opc_t OP_JMP  = 6'h02;
    localparam opc_t OP_BZ   = 6'h04;
    localparam opc_t OP_IS_A = 6'h08;
    localparam opc_t OP_IS_B = 6'h0A;
    localparam opc_t OP_IU_A = 6'h0C;
    localparam opc_t OP_IU_B = 6'h0D;
    localparam opc_t OP_LD   = 6'h23;
    localparam opc_t OP_ST   = 6'h2B;

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
    import mseq_pkg::*;
(
    input  upc_t   addr,
    output uinst_t word
);

    ctrl_t     c;
    nxt_kind_e k;
    upc_t      t;

    always_comb begin
        c = '0;
        k = NX_SEQ;
        t = U_HALT;
        case (addr)
            U_FETCH0: begin c.reg_sel = RS_PC; c.en_reg = 1'b1; c.ld_ma = 1'b1; t = U_FETCH1; end
            U_FETCH1: begin c.en_mem = 1'b1; c.ld_ir = 1'b1; k = NX_WAIT; t = U_FETCH2; end
            U_FETCH2: begin c.reg_sel = RS_PC; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_FETCH3; end
            U_FETCH3: begin
                c.alu_op = AL_ADD4; c.en_alu = 1'b1; c.reg_sel = RS_PC; c.reg_wr = 1'b1;
                k = NX_DISP; t = U_FETCH0;
            end
            U_RR0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_RR1; end
            U_RR1:    begin c.reg_sel = RS_RT; c.en_reg = 1'b1; c.ld_b = 1'b1; t = U_RR2; end
            U_RR2:    begin
                c.alu_op = AL_IR; c.en_alu = 1'b1; c.reg_sel = RS_RD; c.reg_wr = 1'b1;
                t = U_FETCH0;
            end
            U_IS0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_IS1; end
            U_IU0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_IU1; end
            U_IS1:    begin c.ext_sel = EX_SEXT; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_IWB; end
            U_IU1:    begin c.ext_sel = EX_UEXT; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_IWB; end
            U_IWB:    begin
                c.alu_op = AL_IR; c.en_alu = 1'b1; c.reg_sel = RS_RT; c.reg_wr = 1'b1;
                t = U_FETCH0;
            end
            U_LD0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_LD1; end
            U_LD1:    begin c.ext_sel = EX_SEXT; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_LD2; end
            U_LD2:    begin c.alu_op = AL_ADD; c.en_alu = 1'b1; c.ld_ma = 1'b1; t = U_LD3; end
            U_LD3:    begin
                c.en_mem = 1'b1; c.reg_sel = RS_RT; c.reg_wr = 1'b1;
                k = NX_WAIT; t = U_FETCH0;
            end
            U_ST0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_ST1; end
            U_ST1:    begin c.ext_sel = EX_SEXT; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_ST2; end
            U_ST2:    begin c.alu_op = AL_ADD; c.en_alu = 1'b1; c.ld_ma = 1'b1; t = U_ST3; end
            U_ST3:    begin
                c.reg_sel = RS_RT; c.en_reg = 1'b1; c.mem_wr = 1'b1;
                k = NX_WAIT; t = U_FETCH0;
            end
            U_JP0:    begin c.reg_sel = RS_PC; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_JP1; end
            U_JP1:    begin c.ext_sel = EX_IRRAW; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_JP2; end
            U_JP2:    begin
                c.alu_op = AL_JTARG; c.en_alu = 1'b1; c.reg_sel = RS_PC; c.reg_wr = 1'b1;
                t = U_FETCH0;
            end
            U_BZ0:    begin c.reg_sel = RS_RS; c.en_reg = 1'b1; c.ld_a = 1'b1; t = U_BZ1; end
            U_BZ1:    begin
                c.reg_sel = RS_PC; c.en_reg = 1'b1; c.ld_a = 1'b1;
                k = NX_BRZ; t = U_BZ2;
            end
            U_BZ2:    begin c.ext_sel = EX_SEXT_SH2; c.en_imm = 1'b1; c.ld_b = 1'b1; t = U_BZ3; end
            U_BZ3:    begin
                c.alu_op = AL_ADD; c.en_alu = 1'b1; c.reg_sel = RS_PC; c.reg_wr = 1'b1;
                t = U_FETCH0;
            end
            default:  begin k = NX_SEQ; t = U_HALT; end
        endcase
        word = '{ctrl: c, kind: k, target: t};
    end

endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
    import mseq_pkg::*;
(
    input  opc_t opcode,
    output upc_t entry
);

    always_comb begin
        case (opcode)
            OP_RR:            entry = U_RR0;
            OP_IS_A, OP_IS_B: entry = U_IS0;
            OP_IU_A, OP_IU_B: entry = U_IU0;
            OP_LD:            entry = U_LD0;
            OP_ST:            entry = U_ST0;
            OP_JMP:           entry = U_JP0;
            OP_BZ:            entry = U_BZ0;
            default:          entry = U_HALT;
        endcase
    end

endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  upc_t      cur,
    input  nxt_kind_e kind,
    input  upc_t      target,
    input  upc_t      disp_entry,
    input  logic      busy,
    input  logic      zero,
    output upc_t      nxt
);

    always_comb begin
        unique case (kind)
            NX_SEQ:  nxt = target;
            NX_DISP: nxt = disp_entry;
            NX_WAIT: nxt = busy ? cur : target;
            NX_BRZ:  nxt = zero ? target : U_FETCH0;
            default: nxt = U_HALT;
        endcase
    end

endmodule

// File: rtl/microcode_seq.sv
module microcode_seq
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              zero,
    input  logic              busy,
    output logic [CTRL_W-1:0] ctrl
);

    typedef struct packed {
        upc_t upc;
    } seq_state_t;

    seq_state_t st_d, st_q;
    uinst_t     word;
    upc_t       disp_entry;
    upc_t       upc_nxt;
    upc_t       upc_cur;

    assign upc_cur = st_q.upc;

    mseq_rom u_rom (
        .addr (upc_cur),
        .word (word)
    );

    mseq_dispatch u_disp (
        .opcode (opcode),
        .entry  (disp_entry)
    );

    mseq_next u_next (
        .cur        (upc_cur),
        .kind       (word.kind),
        .target     (word.target),
        .disp_entry (disp_entry),
        .busy       (busy),
        .zero       (zero),
        .nxt        (upc_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = upc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.upc <= U_FETCH0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = word.ctrl;

endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
    import mseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              zero,
    input upc_t              upc,
    input logic [CTRL_W-1:0] ctrl
);

    ctrl_t      cw;
    logic [3:0] drivers;
    logic       loads;
    logic       rst_prev_q;

    assign cw      = ctrl_t'(ctrl);
    assign drivers = {cw.en_reg, cw.en_imm, cw.en_alu, cw.en_mem & ~cw.mem_wr};
    assign loads   = cw.ld_ir | cw.ld_a | cw.ld_b | cw.ld_ma | cw.reg_wr | cw.mem_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_prev_q <= 1'b1;
        else        rst_prev_q <= 1'b0;
    end

    AST_RST_TO_FETCH0: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev_q |-> (upc == U_FETCH0)); // R1

    AST_FETCH_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == U_FETCH1) && busy |=> (upc == U_FETCH1)); // R2

    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == U_FETCH1) && !busy |=> (upc == U_FETCH2)); // R2

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == U_HALT) |=> (upc == U_HALT)); // R4

    AST_BRZ_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == U_BZ1) && !zero |=> (upc == U_FETCH0)); // R10

    AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drivers) <= 1); // R11

    AST_LOAD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        loads |-> ($countones(drivers) == 1)); // R11

endmodule

bind microcode_seq mseq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .zero  (zero),
    .upc   (upc_cur),
    .ctrl  (ctrl)
);

// File: tb/microcode_seq_tb.sv
`timescale 1ns/1ps
module microcode_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic        zero = 1'b0;
    logic        busy = 1'b0;
    logic [16:0] ctrl;

    int errors = 0;
    int checks = 0;
    int noise  = 0;
    int st;
    bit done = 1'b0;

    // reference model states (bench numbering)
    localparam int M_F0 = 0, M_F1 = 1, M_F2 = 2, M_F3 = 3;
    localparam int M_RA = 10, M_RB = 11, M_RW = 12;
    localparam int M_SA = 20, M_SB = 21, M_UA = 22, M_UB = 23, M_IW = 24;
    localparam int M_LA = 30, M_LB = 31, M_LM = 32, M_LW = 33;
    localparam int M_WA = 40, M_WB = 41, M_WM = 42, M_WW = 43;
    localparam int M_JA = 50, M_JB = 51, M_JW = 52;
    localparam int M_BA = 60, M_BT = 61, M_BB = 62, M_BW = 63;
    localparam int M_HALT = 99;

    always #4 clk = ~clk;

    microcode_seq u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .zero   (zero),
        .busy   (busy),
        .ctrl   (ctrl)
    );

    // R12 layout: ld_ir ld_a ld_b ld_ma reg_sel[3] reg_wr en_reg ext[2] en_imm alu[2] en_alu mem_wr en_mem
    function automatic logic [16:0] cw(int ir, int a, int b, int ma, int rsel, int rw, int er,
                                       int ext, int ei, int alu, int ea, int mw, int em);
        return {1'(ir), 1'(a), 1'(b), 1'(ma), 3'(rsel), 1'(rw), 1'(er),
                2'(ext), 1'(ei), 2'(alu), 1'(ea), 1'(mw), 1'(em)};
    endfunction

    function automatic logic [16:0] exp_ctrl(int s);
        case (s)
            M_F0: return cw(0,0,0,1, 3,0,1, 0,0, 0,0, 0,0);
            M_F1: return cw(1,0,0,0, 0,0,0, 0,0, 0,0, 0,1);
            M_F2: return cw(0,1,0,0, 3,0,1, 0,0, 0,0, 0,0);
            M_F3: return cw(0,0,0,0, 3,1,0, 0,0, 1,1, 0,0);
            M_RA, M_SA, M_UA, M_LA, M_WA, M_BA:
                  return cw(0,1,0,0, 0,0,1, 0,0, 0,0, 0,0);
            M_RB: return cw(0,0,1,0, 1,0,1, 0,0, 0,0, 0,0);
            M_RW: return cw(0,0,0,0, 2,1,0, 0,0, 2,1, 0,0);
            M_SB, M_LB, M_WB:
                  return cw(0,0,1,0, 0,0,0, 0,1, 0,0, 0,0);
            M_UB: return cw(0,0,1,0, 0,0,0, 1,1, 0,0, 0,0);
            M_IW: return cw(0,0,0,0, 1,1,0, 0,0, 2,1, 0,0);
            M_LM, M_WM:
                  return cw(0,0,0,1, 0,0,0, 0,0, 0,1, 0,0);
            M_LW: return cw(0,0,0,0, 1,1,0, 0,0, 0,0, 0,1);
            M_WW: return cw(0,0,0,0, 1,0,1, 0,0, 0,0, 1,0);
            M_JA: return cw(0,1,0,0, 3,0,1, 0,0, 0,0, 0,0);
            M_JB: return cw(0,0,1,0, 0,0,0, 3,1, 0,0, 0,0);
            M_JW: return cw(0,0,0,0, 3,1,0, 0,0, 3,1, 0,0);
            M_BT: return cw(0,1,0,0, 3,0,1, 0,0, 0,0, 0,0);
            M_BB: return cw(0,0,1,0, 0,0,0, 2,1, 0,0, 0,0);
            M_BW: return cw(0,0,0,0, 3,1,0, 0,0, 0,1, 0,0);
            default: return 17'h0;
        endcase
    endfunction

    function automatic int model_next(int s, logic [5:0] op, logic z, logic b);
        case (s)
            M_F0: return M_F1;
            M_F1: return b ? M_F1 : M_F2;
            M_F2: return M_F3;
            M_F3: begin
                case (op)
                    6'h00:        return M_RA;
                    6'h08, 6'h0A: return M_SA;
                    6'h0C, 6'h0D: return M_UA;
                    6'h23:        return M_LA;
                    6'h2B:        return M_WA;
                    6'h02:        return M_JA;
                    6'h04:        return M_BA;
                    default:      return M_HALT;
                endcase
            end
            M_RA: return M_RB;
            M_RB: return M_RW;
            M_SA: return M_SB;
            M_SB: return M_IW;
            M_UA: return M_UB;
            M_UB: return M_IW;
            M_LA: return M_LB;
            M_LB: return M_LM;
            M_LM: return M_LW;
            M_LW: return b ? M_LW : M_F0;
            M_WA: return M_WB;
            M_WB: return M_WM;
            M_WM: return M_WW;
            M_WW: return b ? M_WW : M_F0;
            M_JA: return M_JB;
            M_JB: return M_JW;
            M_BA: return M_BT;
            M_BT: return z ? M_BB : M_F0;
            M_BB: return M_BW;
            M_HALT: return M_HALT;
            default: return M_F0;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            M_F0, M_F1, M_F2, M_F3: return "R2";
            M_RA:                   return "R3+R5";
            M_RB, M_RW:             return "R5";
            M_SA, M_UA:             return "R3+R6";
            M_SB, M_UB, M_IW:       return "R6";
            M_LA:                   return "R3+R7";
            M_LB, M_LM, M_LW:       return "R7";
            M_WA:                   return "R3+R8";
            M_WB, M_WM, M_WW:       return "R8";
            M_JA:                   return "R3+R9";
            M_JB, M_JW:             return "R9";
            M_BA:                   return "R3+R10";
            M_BT, M_BB, M_BW:       return "R10";
            default:                return "R4";
        endcase
    endfunction

    task automatic check_ctrl(string req, logic [16:0] exp);
        checks++;
        if (ctrl !== exp) begin
            errors++;
            $display("FAIL %s/R12/R13 ctrl got %h expected %h (t=%0t)", req, ctrl, exp, $time);
        end
    endtask

    task automatic check_bus();
        int drv;
        drv = int'(ctrl[8]) + int'(ctrl[5]) + int'(ctrl[2]) + int'(ctrl[0] & ~ctrl[1]);
        checks++;
        if (drv > 1) begin
            errors++;
            $display("FAIL R11 bus drivers got %0d expected at most 1", drv);
        end
    endtask

    // one clock: drive at negedge, compare, advance model after posedge
    task automatic cyc(logic [5:0] op, logic z, logic b);
        opcode = op;
        zero   = z;
        busy   = b;
        #1;
        check_ctrl(req_of(st), exp_ctrl(st));
        check_bus();
        @(posedge clk);
        st = model_next(st, op, z, b);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check_ctrl("R1", exp_ctrl(M_F0));
        @(negedge clk);
        check_ctrl("R1", exp_ctrl(M_F0));
        st = M_F0;
        rst_n = 1'b1;
    endtask

    // runs one instruction from fetch0 back to fetch0 (or a few cycles into halt)
    task automatic run_instr(logic [5:0] op, logic z, int fetch_busy, int mem_busy);
        int fb;
        int mb;
        int guard;
        fb = fetch_busy;
        mb = mem_busy;
        guard = 0;
        do begin
            logic b;
            logic zz;
            noise++;
            if (st == M_F1) begin
                b = (fb > 0);
                fb--;
            end else if (st == M_LW || st == M_WW) begin
                b = (mb > 0);
                mb--;
            end else begin
                b = noise[0];   // R13: busy ignored here
            end
            zz = (st == M_BT) ? z : noise[1];  // R13: zero ignored here
            cyc(op, zz, b);
            guard++;
        end while (st != M_F0 && st != M_HALT && guard < 60);
    endtask

    initial begin
        st = M_F0;
        @(negedge clk);
        do_reset();                       // R1
        run_instr(6'h00, 1'b1, 2, 0);     // R5, fetch held by busy
        run_instr(6'h08, 1'b0, 0, 0);     // R6 signed
        run_instr(6'h0A, 1'b1, 1, 0);     // R6 signed
        run_instr(6'h0C, 1'b0, 0, 0);     // R6 unsigned
        run_instr(6'h0D, 1'b1, 3, 0);     // R6 unsigned
        run_instr(6'h23, 1'b0, 1, 3);     // R7 with memory wait
        run_instr(6'h23, 1'b1, 0, 0);     // R7 no wait
        run_instr(6'h2B, 1'b0, 0, 2);     // R8
        run_instr(6'h02, 1'b0, 1, 0);     // R9
        run_instr(6'h04, 1'b1, 0, 0);     // R10 taken
        run_instr(6'h04, 1'b0, 0, 0);     // R10 not taken
        // R1: reset in the middle of a load sequence
        for (int i = 0; i < 6; i++) cyc(6'h23, 1'b0, 1'b0);
        do_reset();
        run_instr(6'h00, 1'b0, 0, 0);
        // R4: opcode without entry halts and stays halted
        run_instr(6'h3F, 1'b0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(6'(i * 4), i[0], i[1]);
        checks++;
        if (st != M_HALT || ctrl !== 17'h0) begin
            errors++;
            $display("FAIL R4 halt ctrl got %h expected %h", ctrl, 17'h0);
        end
        do_reset();
        run_instr(6'h11, 1'b1, 1, 0);
        for (int i = 0; i < 3; i++) cyc(6'h00, 1'b1, 1'b1);
        do_reset();
        run_instr(6'h2B, 1'b1, 2, 1);
        run_instr(6'h04, 1'b1, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired before the scenarios completed");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule